// File: doc/BRIEF.md
# PCI interrupt line router

The block takes four level-sensitive PCI interrupt request lines and steers each one onto one of sixteen inputs of an interrupt controller. Each line has its own 8-bit steering byte. The steering bytes sit in a byte-addressed configuration space and are reached through a 32-bit write/read port with per-byte enables. A steering value from 0 to 15 names the controller input the line drives. Any larger value, including every value with bit 7 set, leaves the line unconnected.

Internally the block keeps a 64-bit map with one bit per pair of controller input and line, at bit index `target*4 + line`. Each controller output is the OR of the four map bits that belong to it, and it is registered. A write that touches any steering byte clears the map and rebuilds it from the present line levels under the new steering, in the same clock edge.

A combinational query port reports, for a chosen line, whether it is connected and which controller input it drives.

Top module: `pirq_router`

## Requirements
- R1: The steering byte of line `i` sits at byte address 0x60+i. A write updates a byte only when its lane enable is set, where lane k of `cfg_wdata[8k+7:8k]` maps to byte address `{cfg_addr[7:2], k}` and `cfg_addr[1:0]` is ignored. A read returns the stored bytes unchanged in the same lanes.
- R2: A synchronous active-high reset sets every steering byte to 0x80, clears the map and drives every controller output low.
- R3: A steering value of 16 or more disconnects the line. Its level then affects no controller output.
- R4: When line `i` is steered to input `v` (0..15), `irq_out[v]` follows the level of line `i` one clock later.
- R5: Each controller output is the OR of the levels of all connected lines steered to it.
- R6: A write that enables any byte at 0x60..0x63 rebuilds the map from the line levels present at that edge. From the next cycle, the outputs reflect the new steering, and an input that a line has left no longer sees that line.
- R7: The query for line `query_line` returns `query_en`=1 and `query_target` equal to the steering value when that value is below 16. Otherwise it returns `query_en`=0 and `query_target`=0xFF.
- R8: Writes to other addresses, and writes with the relevant lane enables clear, leave the steering bytes unchanged. Reads of bytes outside 0x60..0x63 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address (bits 1:0 ignored) |
| cfg_be | input | 4 | Byte lane enables for writes |
| cfg_wdata | input | 32 | Write data, lane k at bits 8k+7:8k |
| cfg_rdata | output | 32 | Combinational read data for `cfg_addr` |
| pirq_level | input | 4 | Live levels of the four request lines |
| query_line | input | 2 | Line selected for the steering query |
| query_en | output | 1 | Selected line is connected |
| query_target | output | 8 | Controller input of the selected line, or 0xFF |
| irq_out | output | 16 | Registered controller input levels |

## Verification
On every cycle the assertions check the following:
- a disconnected line owns no map bit, and a connected line owns at most one;
- each output matches the OR of its map bits;
- a rebuild leaves each connected line's bit equal to the level sampled at the write;
- steering bytes hold when nothing writes them;
- the query encoding is consistent.

Only the bench's scenarios can show that the correct input is chosen, that lane enables and address decoding pick the right byte, and that a line moved away releases its old output. For these, the bench compares every output against its reference model on every clock.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int LINES       = 4;
    localparam int TARGETS     = 16;
    localparam int ROUTE_W     = 8;
    localparam int CFG_AW      = 8;
    localparam int CFG_BYTES   = 4;
    localparam int ROUTE_BASE  = 'h60;
    localparam logic [ROUTE_W-1:0] ROUTE_RESET = 8'h80;

    typedef logic [ROUTE_W-1:0] route_t;

    typedef struct packed {
        logic   en;
        route_t target;
    } route_info_t;

    function automatic logic route_ok(route_t v, int n_targets);
        return int'(v) < n_targets;
    endfunction

    function automatic route_info_t route_decode(route_t v, int n_targets);
        route_info_t r;
        r.en     = route_ok(v, n_targets);
        r.target = r.en ? v : '1;
        return r;
    endfunction
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
    import pirq_pkg::*;
#(
    parameter int NUM_LINES = LINES,
    parameter int AW        = CFG_AW,
    parameter int NBYTES    = CFG_BYTES,
    parameter int BASE      = ROUTE_BASE
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [AW-1:0]                    addr,
    input  logic [NBYTES-1:0]                be,
    input  logic [NBYTES*8-1:0]              wdata,
    output logic [NBYTES*8-1:0]              rdata,
    output logic [NUM_LINES-1:0][ROUTE_W-1:0] routes_q,
    output logic [NUM_LINES-1:0][ROUTE_W-1:0] routes_next,
    output logic                             rebuild
);
    localparam int LB = $clog2(NBYTES);

    logic [NUM_LINES-1:0] line_hit;

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        localparam int LANE = (BASE + l) % NBYTES;
        localparam int WORD = (BASE + l) / NBYTES;
        assign line_hit[l] = wr_en && (addr[AW-1:LB] == (AW-LB)'(WORD)) && be[LANE];
        assign routes_next[l] = line_hit[l] ? wdata[LANE*8 +: 8] : routes_q[l];

        always_ff @(posedge clk) begin
            if (rst) routes_q[l] <= ROUTE_RESET;
            else     routes_q[l] <= routes_next[l];
        end

        // R2: steering bytes come out of reset disconnected
        a_r2_reset_route: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> routes_q[l] == ROUTE_RESET);
        // R8: a byte not written keeps its value
        a_r8_hold_route: assert property (@(posedge clk) disable iff (rst)
            !line_hit[l] |=> routes_q[l] == $past(routes_q[l]));
    end

    assign rebuild = |line_hit;

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NBYTES; k++) begin
            for (int l = 0; l < NUM_LINES; l++) begin
                if ({addr[AW-1:LB], LB'(k)} == AW'(BASE + l))
                    rdata[k*8 +: 8] = routes_q[l];
            end
        end
    end
endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map
    import pirq_pkg::*;
#(
    parameter int NUM_LINES   = LINES,
    parameter int NUM_TARGETS = TARGETS
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_LINES-1:0]              level,
    input  logic                              rebuild,
    input  logic [NUM_LINES-1:0][ROUTE_W-1:0] routes_q,
    input  logic [NUM_LINES-1:0][ROUTE_W-1:0] routes_next,
    output logic [NUM_TARGETS*NUM_LINES-1:0]  map_q,
    output logic [NUM_TARGETS*NUM_LINES-1:0]  map_next
);
    localparam int MAP_W = NUM_TARGETS * NUM_LINES;
    localparam int TW    = $clog2(NUM_TARGETS);

    always_comb begin
        map_next = rebuild ? '0 : map_q;
        for (int l = 0; l < NUM_LINES; l++) begin
            for (int t = 0; t < NUM_TARGETS; t++) begin
                if (routes_next[l] == ROUTE_W'(t))
                    map_next[t*NUM_LINES + l] = level[l];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) map_q <= '0;
        else     map_q <= map_next;
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_chk
        logic [NUM_TARGETS-1:0] line_bits;
        logic                   routed_bit;
        logic                   line_ok;
        for (genvar t = 0; t < NUM_TARGETS; t++) begin : g_t
            assign line_bits[t] = map_q[t*NUM_LINES + l];
        end
        assign line_ok    = route_ok(routes_q[l], NUM_TARGETS);
        assign routed_bit = line_ok ? line_bits[routes_q[l][TW-1:0]] : 1'b0;

        // R3: a disconnected line owns no map bit
        a_r3_disabled_clear: assert property (@(posedge clk) disable iff (rst)
            !line_ok |-> line_bits == '0);
        // R4: a line drives at most one controller input
        a_r4_single_target: assert property (@(posedge clk) disable iff (rst)
            $onehot0(line_bits));
        // R6: after a rebuild the routed bit equals the sampled level
        a_r6_rebuild_level: assert property (@(posedge clk) disable iff (rst)
            rebuild |=> !line_ok || routed_bit == $past(level[l]));
    end

    logic unused_w;
    assign unused_w = ^MAP_W;
endmodule

// File: rtl/pirq_out_stage.sv
module pirq_out_stage
    import pirq_pkg::*;
#(
    parameter int NUM_LINES   = LINES,
    parameter int NUM_TARGETS = TARGETS
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_TARGETS*NUM_LINES-1:0] map_next,
    output logic [NUM_TARGETS-1:0]           irq_q
);
    for (genvar t = 0; t < NUM_TARGETS; t++) begin : g_tgt
        always_ff @(posedge clk) begin
            if (rst) irq_q[t] <= 1'b0;
            else     irq_q[t] <= |map_next[t*NUM_LINES +: NUM_LINES];
        end
    end
endmodule

// File: rtl/pirq_route_query.sv
module pirq_route_query
    import pirq_pkg::*;
#(
    parameter int NUM_LINES   = LINES,
    parameter int NUM_TARGETS = TARGETS,
    localparam int LW         = $clog2(NUM_LINES)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_LINES-1:0][ROUTE_W-1:0] routes_q,
    input  logic [LW-1:0]                     sel,
    output logic                              en,
    output logic [ROUTE_W-1:0]                target
);
    route_info_t info;

    assign info   = route_decode(routes_q[sel], NUM_TARGETS);
    assign en     = info.en;
    assign target = info.target;

    // R7: encoding of an enabled and a disabled answer
    a_r7_query_enabled: assert property (@(posedge clk) disable iff (rst)
        en |-> int'(target) < NUM_TARGETS);
    a_r7_query_disabled: assert property (@(posedge clk) disable iff (rst)
        !en |-> target == '1);
endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_pkg::*;
#(
    parameter int NUM_LINES   = LINES,
    parameter int NUM_TARGETS = TARGETS,
    parameter int AW          = CFG_AW,
    parameter int NBYTES      = CFG_BYTES,
    parameter int BASE        = ROUTE_BASE,
    localparam int LW         = $clog2(NUM_LINES),
    localparam int DW         = NBYTES * 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_wr_en,
    input  logic [AW-1:0]          cfg_addr,
    input  logic [NBYTES-1:0]      cfg_be,
    input  logic [DW-1:0]          cfg_wdata,
    output logic [DW-1:0]          cfg_rdata,
    input  logic [NUM_LINES-1:0]   pirq_level,
    input  logic [LW-1:0]          query_line,
    output logic                   query_en,
    output logic [ROUTE_W-1:0]     query_target,
    output logic [NUM_TARGETS-1:0] irq_out
);
    logic [NUM_LINES-1:0][ROUTE_W-1:0]   routes_q;
    logic [NUM_LINES-1:0][ROUTE_W-1:0]   routes_next;
    logic                                rebuild;
    logic [NUM_TARGETS*NUM_LINES-1:0]    map_q;
    logic [NUM_TARGETS*NUM_LINES-1:0]    map_next;

    pirq_route_regs #(
        .NUM_LINES(NUM_LINES), .AW(AW), .NBYTES(NBYTES), .BASE(BASE)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .addr(cfg_addr), .be(cfg_be),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .routes_q(routes_q),
        .routes_next(routes_next), .rebuild(rebuild)
    );

    pirq_level_map #(
        .NUM_LINES(NUM_LINES), .NUM_TARGETS(NUM_TARGETS)
    ) u_map (
        .clk(clk), .rst(rst), .level(pirq_level), .rebuild(rebuild),
        .routes_q(routes_q), .routes_next(routes_next),
        .map_q(map_q), .map_next(map_next)
    );

    pirq_out_stage #(
        .NUM_LINES(NUM_LINES), .NUM_TARGETS(NUM_TARGETS)
    ) u_out (
        .clk(clk), .rst(rst), .map_next(map_next), .irq_q(irq_out)
    );

    pirq_route_query #(
        .NUM_LINES(NUM_LINES), .NUM_TARGETS(NUM_TARGETS)
    ) u_query (
        .clk(clk), .rst(rst), .routes_q(routes_q), .sel(query_line),
        .en(query_en), .target(query_target)
    );

    for (genvar t = 0; t < NUM_TARGETS; t++) begin : g_or_chk
        // R5: each output is the OR of its map bits
        a_r5_or_of_map: assert property (@(posedge clk) disable iff (rst)
            irq_out[t] == |map_q[t*NUM_LINES +: NUM_LINES]);
    end

    // R2: outputs are low in the first cycle after reset
    a_r2_reset_out: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> irq_out == '0);
endmodule

// File: tb/test_pirq_router.sv
module test_pirq_router;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = 8'h60;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [3:0]  pirq_level = 4'h0;
    logic [1:0]  query_line = 2'd0;
    logic        query_en;
    logic [7:0]  query_target;
    logic [15:0] irq_out;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    pirq_router i_pirq_router (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .pirq_level(pirq_level), .query_line(query_line), .query_en(query_en),
        .query_target(query_target), .irq_out(irq_out)
    );

    // Behavioural reference: steering bytes and expected outputs
    int          m_route [4];
    logic [15:0] m_out;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_route[i]) m_route[i] = 'h80;
            m_out = '0;
        end else begin
            if (cfg_wr_en) begin
                for (int k = 0; k < 4; k++) begin
                    int ba;
                    ba = int'({cfg_addr[7:2], 2'(k)});
                    if (cfg_be[k] && ba >= 'h60 && ba < 'h64)
                        m_route[ba - 'h60] = int'(cfg_wdata[k*8 +: 8]);
                end
            end
            m_out = '0;
            for (int l = 0; l < 4; l++)
                if (m_route[l] < 16 && pirq_level[l]) m_out[m_route[l]] = 1'b1;
        end
    end

    function automatic logic [31:0] m_read(logic [7:0] a);
        logic [31:0] r;
        r = '0;
        for (int k = 0; k < 4; k++) begin
            int ba;
            ba = int'({a[7:2], 2'(k)});
            if (ba >= 'h60 && ba < 'h64) r[k*8 +: 8] = 8'(m_route[ba - 'h60]);
        end
        return r;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk(irq_out == m_out, "R4 R5 outputs vs model", 32'(irq_out), 32'(m_out));
            chk(cfg_rdata == m_read(cfg_addr), "R1 read data vs model", cfg_rdata,
                m_read(cfg_addr));
            if (m_route[query_line] < 16)
                chk(query_en && query_target == 8'(m_route[query_line]),
                    "R7 query enabled", {23'd0, query_en, query_target},
                    {23'd0, 1'b1, 8'(m_route[query_line])});
            else
                chk(!query_en && query_target == 8'hFF, "R7 query disabled",
                    {23'd0, query_en, query_target}, {23'd0, 1'b0, 8'hFF});
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] b, input logic [31:0] d);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_be = b; cfg_wdata = d;
        step();
        cfg_wr_en = 1'b0; cfg_be = 4'h0;
    endtask

    task automatic at_neg();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) step();
        rst = 1'b0;
        at_neg();
        // R2 reset state
        chk(irq_out == 16'h0, "R2 outputs after reset", 32'(irq_out), 32'h0);
        chk(cfg_rdata == 32'h80808080, "R2 steering after reset", cfg_rdata, 32'h80808080);
        query_line = 2'd2;
        at_neg();
        chk(!query_en && query_target == 8'hFF, "R2 R7 query after reset",
            {23'd0, query_en, query_target}, {23'd0, 1'b0, 8'hFF});

        // R3 disconnected line has no effect
        pirq_level = 4'b0001; step(); at_neg();
        chk(irq_out == 16'h0, "R3 disabled line ignored", 32'(irq_out), 32'h0);

        // R4 line 0 -> input 5
        wr(8'h60, 4'b0001, 32'h05); at_neg();
        chk(irq_out == 16'h0020, "R4 follow level high", 32'(irq_out), 32'h20);
        pirq_level = 4'b0000; step(); at_neg();
        chk(irq_out == 16'h0000, "R4 follow level low", 32'(irq_out), 32'h0);

        // R5 lines 0 and 1 share input 5
        wr(8'h60, 4'b0010, 32'h0500);
        pirq_level = 4'b0010; step(); at_neg();
        chk(irq_out == 16'h0020, "R5 shared by line1", 32'(irq_out), 32'h20);
        pirq_level = 4'b0011; step(); at_neg();
        chk(irq_out == 16'h0020, "R5 shared by both", 32'(irq_out), 32'h20);

        // R6 rebuild on reroute with lines high
        wr(8'h60, 4'b0001, 32'h09); at_neg();
        chk(irq_out == 16'h0220, "R6 reroute line0 to 9", 32'(irq_out), 32'h220);
        wr(8'h60, 4'b0010, 32'h8000); at_neg();
        chk(irq_out == 16'h0200, "R6 line1 leaves input 5", 32'(irq_out), 32'h200);

        // R7 query and boundary values 15 and 16
        query_line = 2'd0; at_neg();
        chk(query_en && query_target == 8'd9, "R7 query line0",
            {23'd0, query_en, query_target}, {23'd0, 1'b1, 8'd9});
        wr(8'h60, 4'b0100, 32'h000F0000);
        wr(8'h60, 4'b1000, 32'h10000000);
        pirq_level = 4'b0100; step(); at_neg();
        chk(irq_out == 16'h8000, "R4 top input 15", 32'(irq_out), 32'h8000);
        pirq_level = 4'b1000; query_line = 2'd3; step(); at_neg();
        chk(irq_out == 16'h0000, "R3 value 16 disables", 32'(irq_out), 32'h0);
        chk(!query_en && query_target == 8'hFF, "R7 query value 16",
            {23'd0, query_en, query_target}, {23'd0, 1'b0, 8'hFF});

        // R8 other addresses and cleared enables
        wr(8'h64, 4'b1111, 32'h01010101);
        wr(8'h60, 4'b0000, 32'h0);
        cfg_addr = 8'h60; at_neg();
        chk(cfg_rdata == 32'h100F8009, "R8 steering unchanged", cfg_rdata, 32'h100F8009);
        cfg_addr = 8'h64; at_neg();
        chk(cfg_rdata == 32'h0, "R8 outside read zero", cfg_rdata, 32'h0);

        // R1 low address bits ignored, single lane
        wr(8'h62, 4'b0001, 32'hAAAA_AA03);
        cfg_addr = 8'h61; at_neg();
        chk(cfg_rdata == 32'h100F8003, "R1 lane write", cfg_rdata, 32'h100F8003);

        // Mixed traffic against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pirq_level = lfsr[3:0];
            query_line = lfsr[5:4];
            cfg_addr = {5'b01100, lfsr[8:6]};
            if (lfsr[11:9] == 3'd0)
                wr({5'b01100, lfsr[14:12]}, lfsr[3:0] ^ lfsr[7:4],
                   {lfsr[15:8], lfsr[7:0], 3'd0, lfsr[4:0], lfsr[12:5]});
            else
                step();
        end

        // R2 reset in the middle of operation
        rst = 1'b1; step(); step(); rst = 1'b0;
        cfg_addr = 8'h60; at_neg();
        chk(irq_out == 16'h0, "R2 outputs after second reset", 32'(irq_out), 32'h0);
        chk(cfg_rdata == 32'h80808080, "R2 steering after second reset", cfg_rdata,
            32'h80808080);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule